// File: doc/BRIEF.md
# Video Memory Bus Responder

This block answers accesses made by a video processor over a multiplexed external memory bus. The processor first puts a 14-bit address on the shared lines and pulses an address strobe. It then lowers an active-low read strobe to fetch a byte, or lowers and raises an active-low write strobe to store one. The shared lines are modelled as a 14-bit input, an 8-bit output and an output-enable flag. The output-enable marks the cycles in which the responder drives the low eight lines.

Behind the bus sit an 8 KB pattern store and a set of 1 KB screen-map pages. The upper quarter of the 14-bit space is a copy of the quarter below it. Screen-map addresses are steered onto physical pages by a run-time mirroring selector. All strobes are sampled on the system clock, and each action is taken on an edge that is found by comparing a strobe with its registered copy.

Top module: `vmb_responder`

## Requirements
- R1: While `rst` is high, `bus_oe` is low. The strobe history is reset to address strobe low, read strobe high and write strobe high.
- R2: A clock where `bus_ale` is high and was low the clock before loads `bus_in` into the address register. Changes on `bus_in` while `bus_ale` stays high do not alter the latched address.
- R3: A clock where `bus_rd_n` is low and was high the clock before sets `bus_oe` high on that edge. On the same edge it places the byte at the latched address on `bus_out`. Neither output changes on any other read-strobe state.
- R4: A clock where `bus_rd_n` is high and was low the clock before clears `bus_oe`.
- R5: A clock where `bus_wr_n` is high and was low the clock before stores `bus_in[7:0]` at the latched address. The value present when the strobe went low is not what gets stored.
- R6: Latched addresses 0x0000 to 0x1FFF select 8192 distinct bytes of pattern storage, indexed by address bits 12:0.
- R7: Latched addresses 0x3000 to 0x3FFF act exactly as the address 0x1000 lower.
- R8: Addresses 0x2000 to 0x2FFF select a screen-map page, with the offset taken from bits 9:0. The page depends on `mirror_mode`: 0 takes bit 10 as the page, 1 takes bit 11, 2 always uses page 0, 3 always uses page 1, and 4 takes bits 11:10 as one of four pages. Codes 5 to 7 behave like code 2.
- R9: Changing `mirror_mode` leaves stored bytes untouched, and the new mode applies to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ale | input | 1 | Address strobe, active high |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 14 | Shared lines as seen by the responder (address, or data in bits 7:0) |
| mirror_mode | input | 3 | Screen-map mirroring selector |
| bus_out | output | 8 | Byte driven onto the shared lines |
| bus_oe | output | 1 | High while the responder drives `bus_out` |

## Verification
One screen-map offset is written on four distinct pages in four-page mode. The same offsets are then read back under every other mirroring code, so that a wrong page bit or a wrong single-screen choice returns a different byte. Two cases check what is sampled on the shared lines. In the first, the lines change while the address strobe is still high, which separates edge capture from level capture. In the second, the data changes between the two write-strobe edges, which shows which edge stores it. Reads through the 0x3000 region and bytes at both ends of the pattern store cover the address folding and the 13-bit pattern index.

// File: rtl/vmb_pkg.sv
package vmb_pkg;

    localparam int BUS_AW   = 14;
    localparam int BYTE_W   = 8;
    localparam int PAT_AW   = 13;
    localparam int PAGE_AW  = 10;
    localparam int PAGE_SW  = 2;

    typedef enum logic [2:0] {
        MIR_VERT  = 3'd0,
        MIR_HORZ  = 3'd1,
        MIR_ONE_A = 3'd2,
        MIR_ONE_B = 3'd3,
        MIR_FOUR  = 3'd4
    } mirror_e;

    typedef struct packed {
        logic               is_pat;
        logic [PAGE_SW-1:0] page;
        logic [PAT_AW-1:0]  pat_idx;
        logic [PAGE_AW-1:0] nt_off;
    } target_t;

    function automatic logic [BUS_AW-1:0] fold_addr(input logic [BUS_AW-1:0] a);
        logic [BUS_AW-1:0] f;
        f = a;
        if (a[BUS_AW-1] && a[BUS_AW-2]) f[BUS_AW-2] = 1'b0;
        return f;
    endfunction

    function automatic logic [PAGE_SW-1:0] pick_page(input mirror_e m,
                                                     input logic [BUS_AW-1:0] a);
        logic [PAGE_SW-1:0] p;
        case (m)
            MIR_VERT:  p = {1'b0, a[PAGE_AW]};
            MIR_HORZ:  p = {1'b0, a[PAGE_AW+1]};
            MIR_ONE_B: p = 2'd1;
            MIR_FOUR:  p = a[PAGE_AW+1:PAGE_AW];
            default:   p = 2'd0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/vmb_strobe_edge.sv
module vmb_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic ale,
    input  logic rd_n,
    input  logic wr_n,
    output logic ale_rise,
    output logic rd_fall,
    output logic rd_rise,
    output logic wr_rise
);
    logic ale_q, rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            rd_q  <= 1'b1;
            wr_q  <= 1'b1;
        end else begin
            ale_q <= ale;
            rd_q  <= rd_n;
            wr_q  <= wr_n;
        end
    end

    always_comb begin
        ale_rise = ale & ~ale_q;
        rd_fall  = ~rd_n & rd_q;
        rd_rise  = rd_n & ~rd_q;
        wr_rise  = wr_n & ~wr_q;
    end
endmodule

// File: rtl/vmb_addr_map.sv
module vmb_addr_map
    import vmb_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    input  logic [2:0]        mode,
    output target_t           tgt
);
    logic [BUS_AW-1:0] folded;

    always_comb begin
        folded      = fold_addr(addr);
        tgt.is_pat  = ~folded[BUS_AW-1];
        tgt.pat_idx = folded[PAT_AW-1:0];
        tgt.nt_off  = folded[PAGE_AW-1:0];
        tgt.page    = pick_page(mirror_e'(mode), folded);
    end
endmodule

// File: rtl/vmb_byte_ram.sv
module vmb_byte_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/vmb_responder.sv
module vmb_responder
    import vmb_pkg::*;
#(
    parameter int NT_PAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ale,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [BUS_AW-1:0] bus_in,
    input  logic [2:0]        mirror_mode,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe
);
    localparam int SEL_W = (NT_PAGES > 1) ? $clog2(NT_PAGES) : 1;

    logic ale_rise, rd_fall, rd_rise, wr_rise;
    logic [BUS_AW-1:0] addr_q;
    target_t tgt;
    logic [BYTE_W-1:0] pat_rd;
    logic [BYTE_W-1:0] nt_rd [NT_PAGES];
    logic [BYTE_W-1:0] sel_byte;
    logic [SEL_W-1:0]  page_sel;

    vmb_strobe_edge u_edge (
        .clk(clk), .rst(rst),
        .ale(bus_ale), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
        .ale_rise(ale_rise), .rd_fall(rd_fall),
        .rd_rise(rd_rise), .wr_rise(wr_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)           addr_q <= '0;
        else if (ale_rise) addr_q <= bus_in;
    end

    vmb_addr_map u_map (
        .addr(addr_q), .mode(mirror_mode), .tgt(tgt)
    );

    vmb_byte_ram #(.AW(PAT_AW), .DW(BYTE_W)) u_pat (
        .clk(clk),
        .we(wr_rise & tgt.is_pat),
        .addr(tgt.pat_idx),
        .wdata(bus_in[BYTE_W-1:0]),
        .rdata(pat_rd)
    );

    assign page_sel = SEL_W'(tgt.page);

    for (genvar g = 0; g < NT_PAGES; g++) begin : g_page
        vmb_byte_ram #(.AW(PAGE_AW), .DW(BYTE_W)) u_nt (
            .clk(clk),
            .we(wr_rise & ~tgt.is_pat & (page_sel == SEL_W'(g))),
            .addr(tgt.nt_off),
            .wdata(bus_in[BYTE_W-1:0]),
            .rdata(nt_rd[g])
        );
    end

    always_comb begin
        if (tgt.is_pat) sel_byte = pat_rd;
        else            sel_byte = nt_rd[page_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_oe  <= 1'b0;
            bus_out <= '0;
        end else if (rd_fall) begin
            bus_oe  <= 1'b1;
            bus_out <= sel_byte;
        end else if (rd_rise) begin
            bus_oe  <= 1'b0;
        end
    end
endmodule

// File: rtl/vmb_responder_chk.sv
module vmb_responder_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_rd_n,
    input logic [7:0] bus_out,
    input logic       bus_oe
);
    p_idle_in_reset_r1: assert property (@(posedge clk)
        rst |=> !bus_oe);

    p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(bus_rd_n)) |=> bus_oe);

    p_release_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(bus_rd_n)) |=> !bus_oe);

    p_oe_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && bus_rd_n == $past(bus_rd_n)) |=> $stable(bus_oe));

    p_data_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$fell(bus_rd_n)) |=> $stable(bus_out));
endmodule

bind vmb_responder vmb_responder_chk u_chk (
    .clk(clk), .rst(rst), .bus_rd_n(bus_rd_n),
    .bus_out(bus_out), .bus_oe(bus_oe)
);

// File: tb/sim_vmb_responder.sv
`timescale 1ns/1ps
module sim_vmb_responder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [13:0] bin = '0;
    logic [2:0]  mode = 3'd0;
    logic [7:0]  bout;
    logic        boe;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vmb_responder u0 (
        .clk(clk), .rst(rst), .bus_ale(ale), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
        .bus_in(bin), .mirror_mode(mode), .bus_out(bout), .bus_oe(boe)
    );

    // behavioural reference: flat byte store, 8192 pattern + 4 x 1024 pages
    byte unsigned mm [12288];
    bit           mv [12288];
    bit  m_ale = 0, m_rd = 1, m_wr = 1, mdoe = 0, mval = 0;
    int  m_addr = 0;
    byte unsigned mdout = 0;

    function automatic int m_index(int a, int md);
        int pg;
        a = a & 'h3FFF;
        if (a >= 'h3000) a = a - 'h1000;
        if (a < 'h2000) return a;
        case (md)
            0: pg = (a >> 10) & 1;
            1: pg = (a >> 11) & 1;
            3: pg = 1;
            4: pg = (a >> 10) & 3;
            default: pg = 0;
        endcase
        return 8192 + pg * 1024 + (a & 'h3FF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int idx;
        if (rst) begin
            m_ale = 0; m_rd = 1; m_wr = 1; m_addr = 0; mdoe = 0;
        end else begin
            idx = m_index(m_addr, int'(mode));
            if (m_rd && !rd_n) begin
                mdoe = 1; mval = mv[idx]; mdout = mm[idx];
            end else if (!m_rd && rd_n) mdoe = 0;
            if (!m_wr && wr_n) begin
                mm[idx] = bin[7:0]; mv[idx] = 1;
            end
            if (!m_ale && ale) m_addr = int'(bin);
            m_ale = ale; m_rd = rd_n; m_wr = wr_n;
        end
        #2;
        if (!done) begin
            check(boe === mdoe, "R3/R4 model oe", int'(boe), int'(mdoe));
            if (mdoe && mval)
                check(bout === mdout, "R3 model data", int'(bout), int'(mdout));
        end
    end

    task automatic latch(input int a);
        @(negedge clk); bin = 14'(a); ale = 1;
        @(negedge clk); ale = 0;
    endtask

    task automatic bus_write(input int a, input int d);
        latch(a);
        @(negedge clk); bin = 14'(d); wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk);
    endtask

    task automatic strobe_read(input int exp, input string req);
        @(negedge clk); rd_n = 0;
        @(negedge clk);
        check(boe === 1'b1, "R3 oe high", int'(boe), 1);
        check(bout === 8'(exp), req, int'(bout), exp);
        rd_n = 1;
        @(negedge clk);
        check(boe === 1'b0, "R4 oe released", int'(boe), 0);
    endtask

    task automatic bus_read(input int a, input int exp, input string req);
        latch(a);
        strobe_read(exp, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(boe === 1'b0, "R1 reset oe", int'(boe), 0);
        rst = 0;
        @(negedge clk);

        // R6: both ends of pattern storage
        mode = 3'd0;
        bus_write('h0000, 'h11);
        bus_write('h1FFF, 'h22);
        bus_read('h0000, 'h11, "R6 pattern low");
        bus_read('h1FFF, 'h22, "R6 pattern high");

        // R8: four distinct pages in four-page mode
        mode = 3'd4;
        bus_write('h2005, 'hA0);
        bus_write('h2405, 'hA1);
        bus_write('h2805, 'hA2);
        bus_write('h2C05, 'hA3);
        bus_read('h2005, 'hA0, "R8 four p0");
        bus_read('h2405, 'hA1, "R8 four p1");
        bus_read('h2805, 'hA2, "R8 four p2");
        bus_read('h2C05, 'hA3, "R8 four p3");

        // R9: mode change keeps contents, new mode applies
        mode = 3'd0;
        bus_read('h2805, 'hA0, "R9 vertical 2805");
        bus_read('h2C05, 'hA1, "R8 vertical 2C05");
        mode = 3'd1;
        bus_read('h2405, 'hA0, "R8 horizontal 2405");
        bus_read('h2805, 'hA1, "R8 horizontal 2805");
        mode = 3'd2;
        bus_read('h2C05, 'hA0, "R8 single A");
        mode = 3'd3;
        bus_read('h2005, 'hA1, "R8 single B");
        mode = 3'd7;
        bus_read('h2805, 'hA0, "R8 code 7 as single A");
        mode = 3'd4;
        bus_read('h2C05, 'hA3, "R9 four after changes");

        // R7: upper quarter folds down
        bus_read('h3C05, 'hA3, "R7 fold read");
        bus_write('h3405, 'h5A);
        bus_read('h2405, 'h5A, "R7 fold write");

        // R2: only the rising edge of the address strobe loads
        @(negedge clk); bin = 14'h0000; ale = 1;
        @(negedge clk); bin = 14'h1FFF;
        @(negedge clk); ale = 0;
        strobe_read('h11, "R2 edge capture");

        // R5: data sampled at the write strobe's rising edge
        latch('h0100);
        @(negedge clk); bin = 14'h0033; wr_n = 0;
        @(negedge clk); bin = 14'h0044;
        @(negedge clk); wr_n = 1;
        @(negedge clk);
        bus_read('h0100, 'h44, "R5 store at rise");

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule